// File: doc/BRIEF.md
# Video Capture Ping-Pong Buffer

This block takes a per-clock video sample stream and stores it in two 64-word by 32-bit buffers that take turns. One buffer fills from the input while the other is written out to memory. A 2-bit mode input selects how samples are packed. In full-resolution mode, 8-bit luma and chroma samples are packed four to a word into separate luma, blue-difference and red-difference regions. Half-resolution mode packs the same way but keeps only every second sample of each component. The two raw modes store one sample per word: 8-bit samples use 64 words and 10-bit samples use 32.

The drain side issues a fixed four memory write requests per buffer. Each request moves sixteen consecutive words to an address formed from a base input plus the buffer and burst offsets. A request is held until the bus grants it. The sixteen data beats then follow under a valid/ready handshake, and the memory side may stall any beat by holding ready low.

The source cannot be stalled, so the block has no input ready signal. Sometimes a buffer fills while the other is still draining. In that case a sticky overrun flag is raised, and further samples are discarded until the drain completes. Software clears the flag by pulsing the acknowledge input. `cfg_mode` must be held constant while a buffer is being filled or drained.

Top module: `vid_pingpong_capture`

## Requirements
- R1: In mode 0 (full resolution), samples tagged 0 (luma), 1 (blue) and 2 (red) use data bits [7:0]. They are packed four to a word, with the earliest sample in bits [7:0]. Luma goes to words 0-31, blue to words 32-47 and red to words 48-63. The buffer is complete when all three regions are full.
- R2: In mode 1 (half resolution), the packing is that of R1, but only the 1st, 3rd, 5th and so on sample of each component is kept. The buffer therefore completes after twice as many input samples.
- R3: In mode 2 (raw 8-bit), each sample's bits [7:0] are stored zero-extended, one per word, 64 per buffer. The tag is ignored.
- R4: In mode 3 (raw 10-bit), each sample's bits [9:0] are stored zero-extended, one per word, 32 per buffer. Words 32-63 of that buffer are drained as zero.
- R5: Each completed buffer is drained as exactly four requests of sixteen beats. `wr_last` is high on the sixteenth beat. Request j of buffer b carries address `cfg_base + b*256 + j*64` (bytes).
- R6: `mem_req` stays high with a stable `mem_addr` until `mem_gnt` is seen. No data beat is presented while a request is waiting.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_data` and `wr_last` hold their values.
- R8: Buffers alternate. The first buffer filled after reset is buffer 0.
- R9: A buffer may complete while the other is still draining. When that happens `ovr_flag` rises, and samples are dropped until that drain ends. The completed buffer then drains with its original contents, and filling resumes in the freed buffer.
- R10: `ovr_flag` holds until `ovr_ack` is sampled high, and clears on the next cycle. A new overrun in the same cycle as the acknowledge wins.
- R11: After reset, `mem_req`, `wr_valid` and `ovr_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Capture mode: 0 full, 1 half, 2 raw 8-bit, 3 raw 10-bit |
| cfg_base | input | 32 | Byte base address of buffer 0 in memory |
| in_valid | input | 1 | A sample is present this cycle |
| in_tag | input | 2 | Component tag: 0 luma, 1 blue, 2 red, 3 unused |
| in_data | input | 10 | Sample value |
| mem_req | output | 1 | Write request pending |
| mem_gnt | input | 1 | Grant for the pending request |
| mem_addr | output | 32 | Byte address of the pending burst |
| wr_valid | output | 1 | Data beat valid |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_data | output | 32 | Beat data |
| wr_last | output | 1 | Final beat of the burst |
| ovr_flag | output | 1 | Sticky overrun indicator |
| ovr_ack | input | 1 | Clears the overrun indicator |

## Verification
A sample presented in a cycle is written to the buffer at the next clock edge. If that sample completes the buffer, the drain request is raised at the same edge. The overrun flag also appears one edge after the completing sample. A grant turns into a first data beat on the following cycle, and each accepted beat advances to the next word one edge later. The bench drives inputs and the grant and ready signals on the falling edge. On that same falling edge it reads the outputs that the preceding rising edge produced. It then compares the words written to memory, and their addresses, against its own model only after the expected beat count has arrived.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

  typedef enum logic [1:0] {
    MODE_FULL  = 2'd0,
    MODE_HALF  = 2'd1,
    MODE_RAW8  = 2'd2,
    MODE_RAW10 = 2'd3
  } cap_mode_e;

  typedef enum logic [1:0] {
    DR_IDLE = 2'd0,
    DR_REQ  = 2'd1,
    DR_DATA = 2'd2
  } drain_state_e;

  localparam int NUM_COMP = 3;

endpackage

// File: rtl/vcap_packer.sv
module vcap_packer
  import vcap_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int SW    = 10,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cap_mode_e     mode,
  input  logic          in_valid,
  input  logic [1:0]    in_tag,
  input  logic [SW-1:0] in_data,
  input  logic          clear,
  output logic          we,
  output logic [IW-1:0] widx,
  output logic [31:0]   wdata,
  output logic          complete
);

  localparam int CNTW = $clog2(2 * WORDS) + 1;
  localparam int RLIM_FULL = WORDS;
  localparam int RLIM_HALF = WORDS / 2;

  logic packed_mode, half_mode, raw10_mode;
  assign packed_mode = (mode == MODE_FULL) || (mode == MODE_HALF);
  assign half_mode   = (mode == MODE_HALF);
  assign raw10_mode  = (mode == MODE_RAW10);

  logic [NUM_COMP-1:0] emit_v;
  logic [NUM_COMP-1:0] full_v;
  logic [IW-1:0]       idx_c  [NUM_COMP];
  logic [31:0]         word_c [NUM_COMP];

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    localparam int LIM  = (c == 0) ? 2 * WORDS : WORDS;
    localparam int BASE = (c == 0) ? 0 : ((c == 1) ? WORDS / 2 : (3 * WORDS) / 4);

    logic [CNTW-1:0] cnt;
    logic            skip_ph;
    logic [23:0]     acc;
    logic            seen, room, take;

    assign seen = in_valid && packed_mode && (in_tag == 2'(c));
    assign room = (cnt != CNTW'(LIM));
    assign take = seen && room && !(half_mode && skip_ph);

    assign emit_v[c] = take && (cnt[1:0] == 2'b11);
    assign full_v[c] = !room || (take && (cnt == CNTW'(LIM - 1)));
    assign idx_c[c]  = IW'(BASE) + IW'(cnt >> 2);
    assign word_c[c] = {in_data[7:0], acc};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt     <= '0;
        skip_ph <= 1'b0;
        acc     <= '0;
      end else if (clear) begin
        cnt     <= '0;
        skip_ph <= 1'b0;
      end else begin
        if (seen && room && half_mode) skip_ph <= ~skip_ph;
        if (take) begin
          cnt <= cnt + 1'b1;
          case (cnt[1:0])
            2'd0:    acc[7:0]   <= in_data[7:0];
            2'd1:    acc[15:8]  <= in_data[7:0];
            2'd2:    acc[23:16] <= in_data[7:0];
            default: ;
          endcase
        end
      end
    end
  end

  // raw modes: one sample per word
  logic [IW:0]   rcnt;
  logic [IW:0]   rlim;
  logic          rhit;
  logic [31:0]   rdata;

  assign rlim  = raw10_mode ? (IW + 1)'(RLIM_HALF) : (IW + 1)'(RLIM_FULL);
  assign rhit  = in_valid && !packed_mode && (rcnt != rlim);
  assign rdata = raw10_mode ? 32'(in_data) : 32'(in_data[7:0]);

  always_ff @(posedge clk) begin
    if (!rst_n)      rcnt <= '0;
    else if (clear)  rcnt <= '0;
    else if (rhit)   rcnt <= rcnt + 1'b1;
  end

  always_comb begin
    we    = rhit || (|emit_v);
    widx  = rcnt[IW-1:0];
    wdata = rdata;
    for (int c = 0; c < NUM_COMP; c++) begin
      if (emit_v[c]) begin
        widx  = idx_c[c];
        wdata = word_c[c];
      end
    end
  end

  assign complete = packed_mode ? ((|emit_v) && (&full_v))
                                : (rhit && (rcnt == rlim - 1'b1));

  // R4: raw 10-bit words never land in the upper half of a buffer
  p_raw10_lower_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && raw10_mode) |-> (widx < IW'(WORDS / 2)));

  // R1: packed writes are only produced for the three component tags
  p_packed_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && packed_mode) |-> (in_tag != 2'd3));

endmodule

// File: rtl/vcap_bufmem.sv
module vcap_bufmem #(
  parameter int WORDS = 64,
  parameter int NBUF  = 2,
  localparam int IW   = $clog2(WORDS),
  localparam int BW   = $clog2(NBUF)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [BW-1:0] wbuf,
  input  logic [IW-1:0] widx,
  input  logic [31:0]   wdata,
  input  logic [BW-1:0] rbuf,
  input  logic [IW-1:0] ridx,
  output logic [31:0]   rdata
);

  logic [31:0] rd_b [NBUF];

  for (genvar b = 0; b < NBUF; b++) begin : g_bank
    logic [31:0] store [WORDS];

    always_ff @(posedge clk) begin
      if (we && (wbuf == BW'(b))) store[widx] <= wdata;
    end

    assign rd_b[b] = store[ridx];
  end

  assign rdata = rd_b[rbuf];

endmodule

// File: rtl/vcap_drain.sv
module vcap_drain
  import vcap_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int BURST = 16,
  parameter int AW    = 32,
  localparam int IW   = $clog2(WORDS),
  localparam int NBURST = WORDS / BURST,
  localparam int NBW  = $clog2(NBURST),
  localparam int BTW  = $clog2(BURST)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_buf,
  input  logic [AW-1:0] base_addr,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic [AW-1:0] mem_addr,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic          wr_last,
  output logic          rd_buf,
  output logic [IW-1:0] rd_idx,
  output logic          busy
);

  drain_state_e     st;
  logic             dbuf;
  logic [NBW-1:0]   burst;
  logic [BTW-1:0]   beat;

  logic last_beat, last_burst;
  assign last_beat  = (beat == BTW'(BURST - 1));
  assign last_burst = (burst == NBW'(NBURST - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= DR_IDLE;
      dbuf  <= 1'b0;
      burst <= '0;
      beat  <= '0;
    end else begin
      case (st)
        DR_IDLE: if (start) begin
          dbuf  <= start_buf;
          burst <= '0;
          beat  <= '0;
          st    <= DR_REQ;
        end
        DR_REQ: if (mem_gnt) begin
          beat <= '0;
          st   <= DR_DATA;
        end
        DR_DATA: if (wr_ready) begin
          if (last_beat) begin
            beat <= '0;
            if (last_burst) st <= DR_IDLE;
            else begin
              burst <= burst + 1'b1;
              st    <= DR_REQ;
            end
          end else begin
            beat <= beat + 1'b1;
          end
        end
        default: st <= DR_IDLE;
      endcase
    end
  end

  assign busy     = (st != DR_IDLE);
  assign mem_req  = (st == DR_REQ);
  assign wr_valid = (st == DR_DATA);
  assign wr_last  = wr_valid && last_beat;
  assign rd_buf   = dbuf;
  assign rd_idx   = {burst, beat};
  assign mem_addr = base_addr + AW'({dbuf, burst, {BTW{1'b0}}, 2'b00});

  // R6: a pending request and its address hold until granted
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  // R6: no data beat while a request waits
  p_no_beat_in_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !wr_valid);

  // R5: after the final beat of a burst the data phase ends
  p_burst_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_last) |=> !wr_valid);

endmodule

// File: rtl/vid_pingpong_capture.sv
module vid_pingpong_capture
  import vcap_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int BURST = 16,
  parameter int AW    = 32,
  parameter int SW    = 10,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_mode,
  input  logic [AW-1:0] cfg_base,
  input  logic          in_valid,
  input  logic [1:0]    in_tag,
  input  logic [SW-1:0] in_data,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic [AW-1:0] mem_addr,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [31:0]   wr_data,
  output logic          wr_last,
  output logic          ovr_flag,
  input  logic          ovr_ack
);

  cap_mode_e mode;
  assign mode = cap_mode_e'(cfg_mode);

  logic          fill_buf;
  logic          blocked;
  logic          pk_we, pk_complete, pk_clear;
  logic [IW-1:0] pk_widx;
  logic [31:0]   pk_wdata;
  logic          drn_busy, drn_rd_buf;
  logic [IW-1:0] drn_rd_idx;
  logic [31:0]   mem_word;
  logic          fill_done, go;

  vcap_packer #(.WORDS(WORDS), .SW(SW)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .in_valid (in_valid),
    .in_tag   (in_tag),
    .in_data  (in_data),
    .clear    (pk_clear),
    .we       (pk_we),
    .widx     (pk_widx),
    .wdata    (pk_wdata),
    .complete (pk_complete)
  );

  vcap_bufmem #(.WORDS(WORDS), .NBUF(2)) u_mem (
    .clk   (clk),
    .we    (pk_we),
    .wbuf  (fill_buf),
    .widx  (pk_widx),
    .wdata (pk_wdata),
    .rbuf  (drn_rd_buf),
    .ridx  (drn_rd_idx),
    .rdata (mem_word)
  );

  vcap_drain #(.WORDS(WORDS), .BURST(BURST), .AW(AW)) u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (go),
    .start_buf (fill_buf),
    .base_addr (cfg_base),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_addr  (mem_addr),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_last   (wr_last),
    .rd_buf    (drn_rd_buf),
    .rd_idx    (drn_rd_idx),
    .busy      (drn_busy)
  );

  // buffer handover
  assign fill_done = pk_complete || blocked;
  assign go        = fill_done && !drn_busy;
  assign pk_clear  = go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_buf <= 1'b0;
      blocked  <= 1'b0;
    end else if (go) begin
      fill_buf <= ~fill_buf;
      blocked  <= 1'b0;
    end else if (fill_done) begin
      blocked  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         ovr_flag <= 1'b0;
    else if (pk_complete && drn_busy)   ovr_flag <= 1'b1;
    else if (ovr_ack)                   ovr_flag <= 1'b0;
  end

  // raw 10-bit buffers only hold the lower half; the rest drains as zero
  assign wr_data = ((mode == MODE_RAW10) && drn_rd_idx[IW-1]) ? 32'd0 : mem_word;

  // R7: a stalled beat holds its data
  p_beat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_last)));

  // R10: overrun flag only falls after an acknowledge
  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_ack) |=> ovr_flag);

  // R9: overrun only rises while a drain is in progress
  p_ovr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(drn_busy));

  // R9: once a buffer completes during a drain, no further samples are stored
  p_drop_while_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_complete && drn_busy) |=> !pk_we);

  // R8: the buffer being drained is never the one being filled
  p_split_bufs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drn_busy |-> (drn_rd_buf != fill_buf));

endmodule

// File: tb/tb_vid_pingpong_capture.sv
`timescale 1ns/1ps
module tb_vid_pingpong_capture;

  localparam logic [31:0] BASE = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_tag = 2'd0;
  logic [9:0]  in_data = 10'd0;
  logic        mem_req;
  logic        mem_gnt = 1'b0;
  logic [31:0] mem_addr;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [31:0] wr_data;
  logic        wr_last;
  logic        ovr_flag;
  logic        ovr_ack = 1'b0;

  vid_pingpong_capture dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_base(BASE),
    .in_valid(in_valid), .in_tag(in_tag), .in_data(in_data),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .ovr_flag(ovr_flag), .ovr_ack(ovr_ack)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory-side model
  logic [31:0] sink [128];
  logic [31:0] req_addr [64];
  int req_total = 0;
  int beat_total = 0;
  int sbeat = 0;
  int cur_off = 0;
  int cyc = 0;
  bit gnt_en = 1, gnt_slow = 0, rdy_slow = 0;
  bit prev_stall = 0;
  logic [31:0] prev_data = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      mem_gnt  = 1'b0;
      wr_ready = 1'b0;
      prev_stall = 0;
    end else begin
      if (prev_stall)
        check(wr_valid === 1'b1 && wr_data === prev_data, "R7 stalled beat held", wr_data, prev_data);
      if (mem_req)
        check(wr_valid === 1'b0, "R6 no beat while request waits", 32'(wr_valid), 32'd0);
      mem_gnt = gnt_en && mem_req && (!gnt_slow || (cyc % 3 == 0));
      if (mem_gnt) begin
        cur_off = int'((mem_addr - BASE) >> 2);
        req_addr[req_total % 64] = mem_addr;
        req_total++;
        sbeat = 0;
      end
      wr_ready = rdy_slow ? ((cyc % 4) == 0 || (cyc % 4) == 3) : 1'b1;
      if (wr_valid && wr_ready) begin
        sink[(cur_off + sbeat) % 128] = wr_data;
        check(wr_last === (sbeat == 15), "R5 last flag on sixteenth beat", 32'(wr_last), 32'(sbeat == 15));
        sbeat++;
        beat_total++;
      end
      prev_stall = wr_valid && !wr_ready;
      prev_data  = wr_data;
    end
  end

  // stimulus helpers
  logic [31:0] exp_w [64];
  logic [31:0] exp_a [64];

  task automatic drive(input logic [1:0] tg, input logic [9:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_tag   = tg;
    in_data  = d;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_beats(input int target);
    while (beat_total < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_buf(input int b, input int req_start, input string req);
    for (int w = 0; w < 64; w++)
      check(sink[b * 64 + w] === exp_w[w], req, sink[b * 64 + w], exp_w[w]);
    for (int j = 0; j < 4; j++)
      check(req_addr[(req_start + j) % 64] === BASE + 32'(b * 256 + j * 64),
            "R5/R8 burst address", req_addr[(req_start + j) % 64], BASE + 32'(b * 256 + j * 64));
  endtask

  // sends a 4:2:2 stream (Y U Y V ...) and builds the expected packed buffer
  task automatic gen_packed(input bit half, input int seed);
    logic [7:0] ys [128];
    logic [7:0] us [64];
    logic [7:0] vs [64];
    int ny = 0, nu = 0, nv = 0, oy = 0, ou = 0, ov = 0;
    int n = half ? 512 : 256;
    for (int i = 0; i < n; i++) begin
      logic [1:0] tg;
      logic [7:0] v;
      tg = (i % 2 == 0) ? 2'd0 : ((i % 4 == 1) ? 2'd1 : 2'd2);
      v  = 8'((i * 13 + seed) & 255);
      case (tg)
        2'd0: begin if (!half || (oy % 2 == 0)) begin ys[ny] = v; ny++; end oy++; end
        2'd1: begin if (!half || (ou % 2 == 0)) begin us[nu] = v; nu++; end ou++; end
        default: begin if (!half || (ov % 2 == 0)) begin vs[nv] = v; nv++; end ov++; end
      endcase
      drive(tg, {2'b10, v});
    end
    idle();
    for (int w = 0; w < 32; w++)
      exp_w[w] = {ys[4*w+3], ys[4*w+2], ys[4*w+1], ys[4*w]};
    for (int w = 0; w < 16; w++) begin
      exp_w[32 + w] = {us[4*w+3], us[4*w+2], us[4*w+1], us[4*w]};
      exp_w[48 + w] = {vs[4*w+3], vs[4*w+2], vs[4*w+1], vs[4*w]};
    end
  endtask

  // scenarios
  task automatic t_reset();
    @(negedge clk);
    check(mem_req === 1'b0, "R11 reset request low", 32'(mem_req), 32'd0);
    check(wr_valid === 1'b0, "R11 reset valid low", 32'(wr_valid), 32'd0);
    check(ovr_flag === 1'b0, "R11 reset overrun low", 32'(ovr_flag), 32'd0);
  endtask

  task automatic t_full(input int b);
    int rs = req_total, bt = beat_total;
    cfg_mode = 2'd0;
    gen_packed(1'b0, 5);
    wait_beats(bt + 64);
    check_buf(b, rs, "R1 full-resolution packing");
    check(req_total == rs + 4, "R5 four requests per buffer", 32'(req_total - rs), 32'd4);
    check(ovr_flag === 1'b0, "R9 no overrun when drained in time", 32'(ovr_flag), 32'd0);
  endtask

  task automatic t_half(input int b);
    int rs = req_total, bt = beat_total;
    cfg_mode = 2'd1;
    gen_packed(1'b1, 77);
    wait_beats(bt + 64);
    check_buf(b, rs, "R2 half-resolution decimation");
    check(req_total == rs + 4, "R5 four requests per buffer", 32'(req_total - rs), 32'd4);
  endtask

  task automatic t_raw8(input int b);
    int rs = req_total, bt = beat_total;
    cfg_mode = 2'd2;
    for (int i = 0; i < 64; i++) begin
      logic [7:0] v;
      v = 8'((i * 29 + 11) & 255);
      exp_w[i] = 32'(v);
      drive(2'(i % 4), {2'b11, v});
    end
    idle();
    wait_beats(bt + 64);
    check_buf(b, rs, "R3 raw 8-bit zero-extended, tag ignored");
  endtask

  task automatic t_raw10(input int b);
    int rs = req_total, bt = beat_total;
    cfg_mode = 2'd3;
    for (int i = 0; i < 32; i++) begin
      logic [9:0] v;
      v = 10'((i * 37 + 517) & 1023);
      exp_w[i] = 32'(v);
      drive(2'(i % 3), v);
    end
    for (int w = 32; w < 64; w++) exp_w[w] = 32'd0;
    idle();
    wait_beats(bt + 64);
    check_buf(b, rs, "R4 raw 10-bit capture and zero upper half");
  endtask

  task automatic t_backpressure(input int b);
    int rs = req_total, bt = beat_total;
    gnt_slow = 1;
    rdy_slow = 1;
    cfg_mode = 2'd0;
    gen_packed(1'b0, 141);
    wait_beats(bt + 64);
    check_buf(b, rs, "R6/R7 data intact under slow grant and stalls");
    gnt_slow = 0;
    rdy_slow = 0;
  endtask

  task automatic t_overrun(input int ba);
    int rs = req_total, bt = beat_total;
    int bb = 1 - ba;
    gnt_en = 0;
    cfg_mode = 2'd0;
    gen_packed(1'b0, 200);
    for (int w = 0; w < 64; w++) exp_a[w] = exp_w[w];
    check(ovr_flag === 1'b0, "R9 no overrun while other buffer free", 32'(ovr_flag), 32'd0);
    gen_packed(1'b0, 9);
    check(ovr_flag === 1'b1, "R9 overrun raised", 32'(ovr_flag), 32'd1);
    for (int i = 0; i < 40; i++) drive(2'(i % 3 == 0 ? 0 : i % 3), 10'h0EE);
    idle();
    check(mem_req === 1'b1 && wr_valid === 1'b0, "R6 request waits for grant", 32'(mem_req), 32'd1);
    gnt_en = 1;
    wait_beats(bt + 128);
    check_buf(bb, rs + 4, "R9 completed buffer keeps contents, extra samples dropped");
    for (int w = 0; w < 64; w++) exp_w[w] = exp_a[w];
    check_buf(ba, rs, "R8 first buffer drained first");
    repeat (5) @(negedge clk);
    check(ovr_flag === 1'b1, "R10 overrun is sticky", 32'(ovr_flag), 32'd1);
    ovr_ack = 1'b1;
    @(negedge clk);
    ovr_ack = 1'b0;
    check(ovr_flag === 1'b0, "R10 acknowledge clears overrun", 32'(ovr_flag), 32'd0);
    @(negedge clk);
    check(ovr_flag === 1'b0, "R10 stays clear after acknowledge", 32'(ovr_flag), 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full(0);
    t_half(1);
    t_raw8(0);
    t_raw10(1);
    t_backpressure(0);
    t_overrun(1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", beat_total, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule